// File: doc/BRIEF.md
# Serial Clock-Enable Controller

This block takes one reference clock and produces thirteen copies of it. Each copy can be switched on or off through a two-wire serial bus. On that bus the block acts only as a receiving slave. A fast system clock oversamples the bus lines, and the block finds START and STOP conditions, the bus address and the data bits from those samples. It acknowledges every byte it accepts by pulling the data line low.

A write transfer has a fixed layout:

1. The address byte.
2. Two header bytes, which the block acknowledges and then discards.
3. Up to three configuration bytes, stored in order starting at the first.

The block has no register pointer. A later configuration byte can only be changed by resending every byte before it.

Each stored enable bit crosses into the reference-clock domain. It is applied only while the reference clock is low. A disabled output therefore sits low, and switching an output on or off never produces a shortened pulse.

Top module: `serial_clock_enable`

## Requirements
- R1: After reset, all 13 enable bits are 1, and every output follows the reference clock.
- R2: START is SDA falling while SCL is high. It restarts address reception at any point in a transfer. STOP is SDA rising while SCL is high. After a STOP, the block ignores all bus activity until the next START.
- R3: The first byte after a START is sent MSB first. If it equals 0xD2 (address 0x69 with the write bit 0), the block drives `sdaOe` high from the SCL falling edge after bit 8 until the SCL falling edge that ends the ninth pulse.
- R4: An address byte of 0xD3 (a read request) or any other non-matching value gets no acknowledge. After it, no byte is acknowledged and no register changes until the next START.
- R5: The two bytes after a matching address are acknowledged, and their contents have no effect on any output.
- R6: Configuration byte 0 bit i enables output i, for i from 0 to 7. A value of 1 enables the output and 0 disables it.
- R7: Configuration byte 1 bits 4..0 enable outputs 12..8. Byte 1 bits 7..5 and all of configuration byte 2 are stored but affect no output.
- R8: Configuration bytes are stored in order starting at byte 0, and each takes effect when its acknowledge ends. A transfer that stops early leaves every byte it did not send unchanged.
- R9: Data bytes after configuration byte 2 are acknowledged and discarded.
- R10: A disabled output stays low. No output is high while the reference clock is low.
- R11: An enable change is applied only while the reference clock is low, so every output high pulse lasts a full reference-clock high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Oversampling system clock for the serial logic and registers |
| rstN | input | 1 | Active-low asynchronous reset |
| refClk | input | 1 | Reference clock that is fanned out |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| sdaOe | output | 1 | When 1, pulls the data line low (acknowledge) |
| clkOut | output | 13 | Gated copies of the reference clock |

## Verification
The bench walks a single enable bit across all thirteen outputs. A design that swapped bytes, shifted the bit order or misplaced the upper field would light the wrong output. It also sends a read request and a foreign address, then follows each with bytes that would change the outputs; a slave that acknowledged them, or did not go idle after them, would alter the outputs. Further transfers cover an early STOP, a repeated START in the middle of a transfer, a byte clocked with no START before it, and data bytes beyond the third. These expose a byte counter that does not reset, or one that wraps into register 0. A pulse-width monitor on every output catches any gating that applies a change while the reference clock is high.

// File: rtl/sce_pkg.sv
`timescale 1ns/1ps
package sce_pkg;
  localparam int NUM_OUT   = 13;
  localparam int NUM_CFG   = 3;
  localparam int HDR_BYTES = 2;
  localparam int CFG_W     = NUM_CFG * 8;
  localparam logic [6:0] DEV_ADDR = 7'h69;
  localparam int CIDX_W    = $clog2(NUM_CFG);
  localparam int BIDX_MAX  = HDR_BYTES + 1 + NUM_CFG;
  localparam int BIDX_W    = $clog2(BIDX_MAX + 1);

  typedef struct packed {
    logic              wrEn;
    logic [CIDX_W-1:0] wrIdx;
    logic [7:0]        wrData;
  } cfgStrobe_t;
endpackage

// File: rtl/sce_ctrl.sv
`timescale 1ns/1ps
module sce_ctrl
  import sce_pkg::*;
(
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output cfgStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK} rxState_t;

  localparam logic [BIDX_W-1:0] FIRST_DATA = BIDX_W'(HDR_BYTES + 1);
  localparam logic [BIDX_W-1:0] END_DATA   = BIDX_W'(HDR_BYTES + 1 + NUM_CFG);
  localparam logic [BIDX_W-1:0] IDX_SAT    = BIDX_W'(BIDX_MAX);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic startSeen, stopSeen, sclRise, sclFall;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow    = sclSync[1];
  assign sdaNow    = sdaSync[1];
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;

  rxState_t          state;
  logic [3:0]        bitCnt;
  logic [7:0]        shiftReg;
  logic [BIDX_W-1:0] byteIdx;
  logic              addrOk;
  logic              isData;

  assign addrOk = (shiftReg == {DEV_ADDR, 1'b0});
  assign isData = (byteIdx >= FIRST_DATA) && (byteIdx < END_DATA);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      byteIdx  <= '0;
      sdaOe    <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe.wrEn <= 1'b0;
      if (startSeen) begin
        state   <= ST_RX;
        bitCnt  <= '0;
        byteIdx <= '0;
        sdaOe   <= 1'b0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaNow};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (byteIdx == '0 && !addrOk) begin
                state <= ST_IDLE;
              end else begin
                state <= ST_ACK;
                sdaOe <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              sdaOe  <= 1'b0;
              state  <= ST_RX;
              bitCnt <= '0;
              if (isData) begin
                strobe.wrEn   <= 1'b1;
                strobe.wrIdx  <= CIDX_W'(byteIdx - FIRST_DATA);
                strobe.wrData <= shiftReg;
              end
              if (byteIdx != IDX_SAT) byteIdx <= byteIdx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sce_datapath.sv
`timescale 1ns/1ps
module sce_datapath
  import sce_pkg::*;
(
  input  logic               sysClk,
  input  logic               rstN,
  input  logic               refClk,
  input  cfgStrobe_t         strobe,
  output logic [CFG_W-1:0]   cfgWord,
  output logic [NUM_OUT-1:0] clkOut
);
  logic [7:0] cfgReg [NUM_CFG];

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CFG; i++) cfgReg[i] <= 8'hFF;
    end else if (strobe.wrEn) begin
      cfgReg[strobe.wrIdx] <= strobe.wrData;
    end
  end

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_flat
    assign cfgWord[8*g +: 8] = cfgReg[g];
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_gate
    logic [1:0] syncQ;
    logic       enLow;
    always_ff @(posedge refClk or negedge rstN) begin
      if (!rstN) syncQ <= 2'b11;
      else       syncQ <= {syncQ[0], cfgWord[o]};
    end
    always_ff @(negedge refClk or negedge rstN) begin
      if (!rstN) enLow <= 1'b1;
      else       enLow <= syncQ[1];
    end
    assign clkOut[o] = refClk & enLow;
  end
endmodule

// File: rtl/serial_clock_enable.sv
`timescale 1ns/1ps
module serial_clock_enable
  import sce_pkg::*;
(
  input  logic               sysClk,
  input  logic               rstN,
  input  logic               refClk,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  output logic [NUM_OUT-1:0] clkOut
);
  cfgStrobe_t       strobe;
  logic [CFG_W-1:0] cfgWord;

  sce_ctrl u_ctrl (
    .sysClk (sysClk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .sdaOe  (sdaOe),
    .strobe (strobe)
  );

  sce_datapath u_data (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .refClk  (refClk),
    .strobe  (strobe),
    .cfgWord (cfgWord),
    .clkOut  (clkOut)
  );
endmodule

// File: rtl/sce_checker.sv
`timescale 1ns/1ps
module sce_checker
  import sce_pkg::*;
(
  input logic               sysClk,
  input logic               rstN,
  input logic               refClk,
  input logic               sclIn,
  input logic               sdaOe,
  input cfgStrobe_t         strobe,
  input logic [CFG_W-1:0]   cfgWord,
  input logic [NUM_OUT-1:0] clkOut
);
  p_reset_all_on_r1: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(rstN) |-> (cfgWord == '1));

  p_ack_scl_low_r3: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  p_wr_after_ack_r8: assert property (@(posedge sysClk) disable iff (!rstN)
    strobe.wrEn |-> $past(sdaOe));

  p_ref_low_quiet_r10: assert property (@(posedge sysClk) disable iff (!rstN)
    !refClk |-> (clkOut == '0));

  p_no_runt_r11: assert property (@(posedge sysClk) disable iff (!rstN)
    (refClk && $past(refClk)) |-> $stable(clkOut));
endmodule

bind serial_clock_enable sce_checker u_chk (.*);

// File: tb/tb_serial_clock_enable.sv
`timescale 1ns/1ps
module tb_serial_clock_enable;
  localparam int NOUT = 13;
  localparam int Q    = 100;
  localparam int REF_HALF = 16;

  logic sysClk = 1'b0;
  logic refClk = 1'b0;
  logic rstN   = 1'b0;
  logic sclM   = 1'b1;
  logic sdaM   = 1'b1;
  logic sdaLine;
  logic sdaOe;
  logic [NOUT-1:0] clkOut;

  int errors = 0;
  int checks = 0;
  int runtCount = 0;
  logic [7:0] mb [3];
  logic [NOUT-1:0] expEn;

  always #5 sysClk = ~sysClk;
  initial begin
    #2;
    forever #(REF_HALF) refClk = ~refClk;
  end

  assign sdaLine = sdaM & ~sdaOe;

  serial_clock_enable dut (
    .sysClk (sysClk),
    .rstN   (rstN),
    .refClk (refClk),
    .sclIn  (sclM),
    .sdaIn  (sdaLine),
    .sdaOe  (sdaOe),
    .clkOut (clkOut)
  );

  // R11: every high pulse must last a full reference high phase
  for (genvar g = 0; g < NOUT; g++) begin : g_mon
    realtime riseT;
    bit seen = 1'b0;
    always @(posedge clkOut[g]) begin riseT = $realtime; seen = 1'b1; end
    always @(negedge clkOut[g]) begin
      if (seen && ($realtime - riseT) != REF_HALF) runtCount++;
      seen = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; #(Q);
    sclM = 1'b1; #(Q);
    sdaM = 1'b0; #(Q);
    sclM = 1'b0; #(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; #(Q);
    sclM = 1'b1; #(Q);
    sdaM = 1'b1; #(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #(Q);
      sclM = 1'b1; #(2*Q);
      sclM = 1'b0; #(Q);
    end
    sdaM = 1'b1; #(Q);
    sclM = 1'b1; #(Q);
    acked = ~sdaLine;
    #(Q);
    sclM = 1'b0; #(Q);
  endtask

  function automatic void refreshExp();
    expEn = {mb[1][4:0], mb[0]};
  endfunction

  task automatic xfer(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                      input logic [39:0] payload, input int nData, input bit expAck,
                      input bit doStop, input string req);
    bit a;
    busStart();
    sendByte(addr, a);
    check(a == expAck, req, "address ack", a, expAck);
    sendByte(cmd, a);
    check(a == expAck, "R5", "command ack", a, expAck);
    sendByte(cnt, a);
    check(a == expAck, "R5", "count ack", a, expAck);
    for (int i = 0; i < nData; i++) begin
      sendByte(payload[8*i +: 8], a);
      check(a == expAck, (i >= 3) ? "R9" : "R8", "data ack", a, expAck);
      if (expAck && i < 3) mb[i] = payload[8*i +: 8];
    end
    if (doStop) busStop();
    refreshExp();
  endtask

  task automatic checkOut(input string req);
    repeat (4) @(posedge refClk);
    @(posedge refClk); #4;
    check(clkOut == expEn, req, "outputs in high phase", clkOut, expEn);
    @(negedge refClk); #4;
    check(clkOut == '0, "R10", "outputs in low phase", clkOut, 0);
  endtask

  function automatic logic [39:0] enBytes(input logic [NOUT-1:0] en, input logic [2:0] top);
    return {16'h0, 8'h00, {top, en[12:8]}, en[7:0]};
  endfunction

  initial begin
    #(1_500_000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit a;
    for (int i = 0; i < 3; i++) mb[i] = 8'hFF;
    refreshExp();
    #4;
    check(sdaOe == 1'b0, "R1", "sdaOe in reset", sdaOe, 0);
    repeat (5) @(posedge sysClk);
    #3 rstN = 1'b1;
    checkOut("R1");

    // R6 R7: walking single enable, varied header contents (R5)
    for (int k = 0; k < NOUT; k++) begin
      xfer(8'hD2, 8'(k * 37), 8'(~k), enBytes(NOUT'(1) << k, 3'b000), 2, 1'b1, 1'b1,
           (k < 8) ? "R6" : "R7");
      checkOut((k < 8) ? "R6" : "R7");
    end

    // R7: upper bits of byte1 and byte2 have no effect
    xfer(8'hD2, 8'hFF, 8'h00, {16'h0, 8'h00, 8'hE0, 8'hFF}, 3, 1'b1, 1'b1, "R7");
    checkOut("R7");
    xfer(8'hD2, 8'h00, 8'hFF, {16'h0, 8'hFF, 8'hFF, 8'hFF}, 3, 1'b1, 1'b1, "R7");
    checkOut("R7");

    // R8: only byte0 sent, byte1 kept
    xfer(8'hD2, 8'h12, 8'h34, {32'h0, 8'h0F}, 1, 1'b1, 1'b1, "R8");
    checkOut("R8");

    // R5: header only, no change
    xfer(8'hD2, 8'h00, 8'h00, 40'h0, 0, 1'b1, 1'b1, "R5");
    checkOut("R5");

    // R9: extra bytes acked and discarded, no wrap into byte0
    xfer(8'hD2, 8'h01, 8'h05, {8'h55, 8'hAA, 8'h00, 8'h00, 8'h00}, 5, 1'b1, 1'b1, "R9");
    checkOut("R9");

    // R4: read request and foreign address ignored
    xfer(8'hD3, 8'hFF, 8'hFF, 40'hFF_FFFF_FFFF, 2, 1'b0, 1'b1, "R4");
    checkOut("R4");
    xfer(8'hA4, 8'hFF, 8'hFF, 40'hFF_FFFF_FFFF, 2, 1'b0, 1'b1, "R4");
    checkOut("R4");

    // R3: address acked
    xfer(8'hD2, 8'h00, 8'h00, enBytes(13'h1ABC, 3'b000), 2, 1'b1, 1'b1, "R3");
    checkOut("R3");

    // R2: repeated START mid-transfer restarts address phase
    xfer(8'hD2, 8'h00, 8'h00, {32'h0, 8'h33}, 1, 1'b1, 1'b0, "R2");
    xfer(8'hD2, 8'h00, 8'h00, {24'h0, 8'h1F, 8'hCC}, 2, 1'b1, 1'b1, "R2");
    checkOut("R2");

    // R2: after STOP, bytes without a START are ignored
    busStart();
    sendByte(8'hD2, a);
    check(a == 1'b1, "R3", "address ack before stop", a, 1);
    sendByte(8'h00, a);
    busStop();
    sendByte(8'hD2, a);
    check(a == 1'b0, "R2", "byte without START", a, 0);
    for (int i = 0; i < 3; i++) begin
      sendByte(8'h00, a);
      check(a == 1'b0, "R2", "byte without START", a, 0);
    end
    busStop();
    checkOut("R2");

    // R11: toggle all outputs back on, then check pulse widths
    xfer(8'hD2, 8'h00, 8'h00, {16'h0, 8'hFF, 8'hFF, 8'hFF}, 3, 1'b1, 1'b1, "R11");
    checkOut("R11");
    check(runtCount == 0, "R11", "short pulses seen", runtCount, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule